// File: doc/BRIEF.md
# Serial Flash Page Program Engine

This block is the slave-side command logic of a serial NOR flash for one operation: programming up to one page. It watches an SPI mode 0 link (chip select active low, data sampled on the rising SCK edge, MSB first), decodes an 8-bit opcode, collects a 24-bit address, and stores the data bytes that follow in a 256-byte page buffer. Every buffer slot has a flag that records whether the command wrote it. When chip select rises, the engine either commits the buffer to a behavioural memory array or drops the command.

On commit a self-timed cycle starts. Its length is a parameter in clock cycles. During the cycle the flagged bytes are ANDed into the array one per clock, and the status register shows busy. The status register also holds a write-enable latch and a program-error flag, and it is read over SPI. Each sector has a lock input. A command aimed at a locked sector is dropped, as is a malformed command, and either case clears the write-enable latch. A combinational read port onto the array lets the surrounding chip see the stored bytes.

Top module: `fpp_engine`

## Requirements
- R1: After reset:
  - the status register is 0x00;
  - `spi_so` is 0;
  - every array byte reads 0xFF.
- R2: A write-enable opcode 0x06 sets the write-enable latch (status bit 1), provided chip select rises after exactly 8 clocks while not busy.
  - Opcode 0x05 returns the status byte on `spi_so`, MSB first, changing on falling SCK edges and starting after the opcode.
  - The status bits are: bit 0 busy, bit 1 write-enable latch, bit 5 program error. All other bits are 0.
- R3: Opcode 0x02 issued while the write-enable latch is 0 is ignored. The array is unchanged and the latch stays 0.
- R4: Opcode 0x02 with the latch set is followed by three address bytes (MSB first) and data bytes. When chip select rises, the following happens:
  - busy reads 1 and the latch reads 0 while the cycle runs;
  - busy returns to 0 once PROG_CYCLES clocks have passed;
  - the data is then present in the array.
- R5: Data wraps inside the page. Address bits 7..0 give the start byte, and the byte after offset 0xFF goes to offset 0x00 of the same page. For example, start 0x0001FE with 3 bytes writes offsets 0xFE, 0xFF and 0x00.
- R6: When more than 256 data bytes are sent, only the last 256 are programmed.
- R7: Page bytes that received no data in the command keep their previous value. Address bits above the array size are ignored.
- R8: If chip select rises before all three address bytes, or before one full data byte, nothing is programmed and the latch is cleared.
- R9: If chip select rises after a clock count that is not a multiple of 8, nothing is programmed and the latch is cleared.
- R10: The sector is the top log2(NUM_SECTORS) bits of the in-array address. If `sector_lock` is set for the target sector, the command is not executed, busy stays 0 and the latch is cleared.
- R11: Programming only clears bits: the new value is old AND data.
  - A byte that would need a 0-to-1 change sets the program-error flag.
  - The flag is cleared when the next program cycle starts.
- R12: While busy, every opcode except 0x05 is ignored, including 0x06.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, mode 0 |
| spi_si | input | 1 | SPI serial data in |
| spi_so | output | 1 | SPI serial data out (status bits) |
| sector_lock | input | NUM_SECTORS | One lock bit per sector |
| rd_addr | input | MEM_AW | Array read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The hardest condition to reach from the ports is a command that overruns the page, so that the final 256 bytes overwrite earlier ones in the buffer. The stimulus table therefore includes a 258-byte program whose byte pattern changes after the first 256 bytes. This makes the two overwritten slots tell old data from new.

Program-error flagging needs a location that has already been programmed. The bench first writes a byte and later programs the same location with 0xFF. Commands sent while busy are also hard to reach, because they must land inside the self-timed window. The bench issues a write-enable and a status read straight after a commit, while the window is still open.

// File: rtl/fpp_pkg.sv
package fpp_pkg;
   localparam int PAGE_AW    = 8;
   localparam int PAGE_BYTES = 1 << PAGE_AW;

   localparam logic [7:0] OPC_WREN = 8'h06;
   localparam logic [7:0] OPC_PROG = 8'h02;
   localparam logic [7:0] OPC_RDSR = 8'h05;

   localparam int SR_BUSY = 0;
   localparam int SR_WEL  = 1;
   localparam int SR_ERR  = 5;

   typedef enum logic [2:0] {
      CMD_OPC,
      CMD_WREN,
      CMD_ADDR,
      CMD_DATA,
      CMD_STAT,
      CMD_SKIP
   } cmd_state_e;
endpackage

// File: rtl/fpp_spi_rx.sv
module fpp_spi_rx #(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cs_n_i,
   input  logic       sck_i,
   input  logic       si_i,
   output logic       byte_vld_o,
   output logic [7:0] byte_o,
   output logic       cs_rise_o,
   output logic       aligned_o,
   output logic       sck_fall_o
);
   logic cs_s, sck_s, si_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign cs_s  = cs_n_i;
         assign sck_s = sck_i;
         assign si_s  = si_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] cs_ff, sck_ff, si_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cs_ff  <= '1;
               sck_ff <= '0;
               si_ff  <= '0;
            end else begin
               cs_ff  <= SYNC_STAGES'({cs_ff, cs_n_i});
               sck_ff <= SYNC_STAGES'({sck_ff, sck_i});
               si_ff  <= SYNC_STAGES'({si_ff, si_i});
            end
         end
         assign cs_s  = cs_ff[SYNC_STAGES-1];
         assign sck_s = sck_ff[SYNC_STAGES-1];
         assign si_s  = si_ff[SYNC_STAGES-1];
      end
   endgenerate

   logic       sck_q, cs_q;
   logic [2:0] bit_cnt;
   logic [6:0] shreg;

   wire sck_rise = sck_s & ~sck_q & ~cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q      <= 1'b0;
         cs_q       <= 1'b1;
         bit_cnt    <= '0;
         shreg      <= '0;
         byte_vld_o <= 1'b0;
         byte_o     <= '0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
         if (cs_s) begin
            bit_cnt    <= '0;
            byte_vld_o <= 1'b0;
         end else if (sck_rise) begin
            shreg      <= {shreg[5:0], si_s};
            bit_cnt    <= bit_cnt + 3'd1;
            byte_vld_o <= (bit_cnt == 3'd7);
            byte_o     <= {shreg, si_s};
         end else begin
            byte_vld_o <= 1'b0;
         end
      end
   end

   assign cs_rise_o  = cs_s & ~cs_q;
   assign aligned_o  = (bit_cnt == 3'd0);
   assign sck_fall_o = ~sck_s & sck_q & ~cs_s;

   a_r9_byte_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> bit_cnt == 3'd0);
endmodule

// File: rtl/fpp_page_buf.sv
module fpp_page_buf
   import fpp_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PAGE_AW-1:0] start_off_i,
   input  logic               wr_i,
   input  logic [7:0]         wr_data_i,
   input  logic [PAGE_AW-1:0] rd_idx_i,
   output logic [7:0]         rd_data_o,
   output logic               rd_mask_o
);
   logic [7:0]            store [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] mask_q;
   logic [PAGE_AW-1:0]    ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         ptr_q  <= '0;
      end else if (start_i) begin
         mask_q <= '0;
         ptr_q  <= start_off_i;
      end else if (wr_i) begin
         mask_q[ptr_q] <= 1'b1;
         ptr_q         <= ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_i && !start_i) store[ptr_q] <= wr_data_i;
   end

   assign rd_data_o = store[rd_idx_i];
   assign rd_mask_o = mask_q[rd_idx_i];

   a_r5_offset_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !start_i) |=> ptr_q == PAGE_AW'($past(ptr_q) + 1'b1));
   a_r6_slot_marked: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !start_i) |=> mask_q[$past(ptr_q)]);
endmodule

// File: rtl/fpp_mem_array.sv
module fpp_mem_array #(
   parameter int AW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] waddr_i,
   input  logic [7:0]    wdata_i,
   output logic          fail_o,
   input  logic [AW-1:0] raddr_i,
   output logic [7:0]    rdata_o
);
   localparam int DEPTH = 1 << AW;
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      end else if (we_i) begin
         mem[waddr_i] <= mem[waddr_i] & wdata_i;
      end
   end

   assign fail_o  = (mem[waddr_i] & wdata_i) != wdata_i;
   assign rdata_o = mem[raddr_i];

   a_r11_never_sets_bits: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mem[$past(waddr_i)] & ~$past(mem[waddr_i])) == 8'h00);
endmodule

// File: rtl/fpp_engine.sv
module fpp_engine
   import fpp_pkg::*;
#(
   parameter int ADDR_W      = 24,
   parameter int MEM_PAGES   = 8,
   parameter int NUM_SECTORS = 4,
   parameter int PROG_CYCLES = 300,
   parameter int SYNC_STAGES = 2,
   localparam int MEM_AW     = PAGE_AW + $clog2(MEM_PAGES)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   spi_cs_n,
   input  logic                   spi_sck,
   input  logic                   spi_si,
   output logic                   spi_so,
   input  logic [NUM_SECTORS-1:0] sector_lock,
   input  logic [MEM_AW-1:0]      rd_addr,
   output logic [7:0]             rd_data
);
   localparam int ADDR_BYTES = ADDR_W / 8;
   localparam int AB_W       = $clog2(ADDR_BYTES);
   localparam int SECT_W     = $clog2(NUM_SECTORS);
   localparam int CNT_W      = $clog2(PROG_CYCLES);

   generate
      if (ADDR_W % 8 != 0 || ADDR_W < MEM_AW) begin : g_bad_addr
         $error("ADDR_W must be whole bytes and cover the array");
      end
      if (PROG_CYCLES <= PAGE_BYTES) begin : g_bad_cycles
         $error("PROG_CYCLES must exceed the page size");
      end
      if (NUM_SECTORS < 2 || (1 << SECT_W) != NUM_SECTORS || NUM_SECTORS > MEM_PAGES) begin : g_bad_sect
         $error("NUM_SECTORS must be a power of two between 2 and MEM_PAGES");
      end
      if ((1 << (MEM_AW - PAGE_AW)) != MEM_PAGES) begin : g_bad_pages
         $error("MEM_PAGES must be a power of two");
      end
   endgenerate

   logic       byte_vld, cs_rise, aligned, sck_fall;
   logic [7:0] rx_byte;

   fpp_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck), .si_i(spi_si),
      .byte_vld_o(byte_vld), .byte_o(rx_byte), .cs_rise_o(cs_rise),
      .aligned_o(aligned), .sck_fall_o(sck_fall));

   cmd_state_e          state_q;
   logic [MEM_AW-1:0]   addr_q;
   logic [AB_W-1:0]     addr_cnt_q;
   logic                got_data_q;
   logic                busy_q, wel_q, err_q;
   logic [CNT_W-1:0]    busy_cnt_q;
   logic [7:0]          sr_sh_q;
   logic                so_q;

   wire [7:0] status = {2'b00, err_q, 3'b000, wel_q, busy_q};
   wire       prot_hit = sector_lock[addr_q[MEM_AW-1 -: SECT_W]];
   wire       commit = cs_rise && state_q == CMD_DATA && got_data_q && aligned && !prot_hit;
   wire       last_addr = (addr_cnt_q == AB_W'(ADDR_BYTES - 1));

   // page buffer control
   wire pb_start = byte_vld && !cs_rise && state_q == CMD_ADDR && last_addr;
   wire pb_wr    = byte_vld && !cs_rise && state_q == CMD_DATA;
   wire [PAGE_AW-1:0] seq_idx = busy_cnt_q[PAGE_AW-1:0];
   logic [7:0] pb_data;
   logic       pb_mask;

   fpp_page_buf u_buf (
      .clk(clk), .rst_n(rst_n), .start_i(pb_start), .start_off_i(rx_byte),
      .wr_i(pb_wr), .wr_data_i(rx_byte), .rd_idx_i(seq_idx),
      .rd_data_o(pb_data), .rd_mask_o(pb_mask));

   // one buffered byte per clock during the first page-size clocks of the cycle
   wire arr_we = busy_q && (busy_cnt_q < CNT_W'(PAGE_BYTES)) && pb_mask;
   logic arr_fail;

   fpp_mem_array #(.AW(MEM_AW)) u_mem (
      .clk(clk), .rst_n(rst_n), .we_i(arr_we),
      .waddr_i({addr_q[MEM_AW-1:PAGE_AW], seq_idx}), .wdata_i(pb_data),
      .fail_o(arr_fail), .raddr_i(rd_addr), .rdata_o(rd_data));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= CMD_OPC;
         addr_q     <= '0;
         addr_cnt_q <= '0;
         got_data_q <= 1'b0;
         busy_q     <= 1'b0;
         wel_q      <= 1'b0;
         err_q      <= 1'b0;
         busy_cnt_q <= '0;
         sr_sh_q    <= '0;
         so_q       <= 1'b0;
      end else begin
         if (busy_q) begin
            if (arr_we && arr_fail) err_q <= 1'b1;
            if (busy_cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
               busy_q     <= 1'b0;
               busy_cnt_q <= '0;
            end else begin
               busy_cnt_q <= busy_cnt_q + 1'b1;
            end
         end
         if (state_q == CMD_STAT && sck_fall) begin
            so_q    <= sr_sh_q[7];
            sr_sh_q <= {sr_sh_q[6:0], sr_sh_q[7]};
         end
         if (cs_rise) begin
            state_q    <= CMD_OPC;
            addr_cnt_q <= '0;
            got_data_q <= 1'b0;
            so_q       <= 1'b0;
            case (state_q)
               CMD_WREN: if (aligned) wel_q <= 1'b1;
               CMD_ADDR: wel_q <= 1'b0;
               CMD_DATA: begin
                  wel_q <= 1'b0;
                  if (commit) begin
                     busy_q     <= 1'b1;
                     busy_cnt_q <= '0;
                     err_q      <= 1'b0;
                  end
               end
               default: ;
            endcase
         end else if (byte_vld) begin
            case (state_q)
               CMD_OPC: begin
                  if (rx_byte == OPC_RDSR) begin
                     state_q <= CMD_STAT;
                     sr_sh_q <= status;
                  end else if (!busy_q && rx_byte == OPC_WREN) begin
                     state_q <= CMD_WREN;
                  end else if (!busy_q && wel_q && rx_byte == OPC_PROG) begin
                     state_q <= CMD_ADDR;
                  end else begin
                     state_q <= CMD_SKIP;
                  end
               end
               CMD_WREN: state_q <= CMD_SKIP;
               CMD_ADDR: begin
                  addr_q     <= MEM_AW'({addr_q, rx_byte});
                  addr_cnt_q <= addr_cnt_q + 1'b1;
                  if (last_addr) state_q <= CMD_DATA;
               end
               CMD_DATA: got_data_q <= 1'b1;
               default: ;
            endcase
         end
      end
   end

   assign spi_so = so_q;

   a_r4_wel_low_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> !wel_q);
   a_r8_short_addr_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && state_q == CMD_ADDR) |=> !wel_q && !busy_q);
   a_r10_locked_no_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && state_q == CMD_DATA && prot_hit) |=> !busy_q && !wel_q);
   a_r9_odd_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && state_q == CMD_DATA && !aligned) |=> !busy_q);
   a_r12_no_cmd_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> state_q != CMD_ADDR && state_q != CMD_WREN);
endmodule

// File: tb/fpp_engine_bench.sv
module fpp_engine_bench;
   localparam int HALF = 6;
   localparam int AW   = 11;
   localparam logic [3:0] LOCK = 4'b1000;

   typedef struct packed {
      logic [23:0] addr;
      logic [9:0]  len;
      logic [7:0]  fill;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{24'h000010, 10'd4,   8'hA0},
      '{24'h0001FE, 10'd3,   8'h11},
      '{24'h000200, 10'd258, 8'h05},
      '{24'h000640, 10'd2,   8'h3C},
      '{24'h000380, 10'd5,   8'hF0},
      '{24'hFF0470, 10'd1,   8'h5A}
   };

   logic clk = 0, rst_n = 0;
   logic cs_n = 1, sck = 0, si = 0;
   logic so;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0] rd_data;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] model [2048];

   always #4 clk = ~clk;

   fpp_engine u_fpp_engine (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_si(si),
      .spi_so(so), .sector_lock(LOCK), .rd_addr(rd_addr), .rd_data(rd_data));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
      for (int b = 7; b >= 0; b--) begin
         si = tx[b];
         repeat (HALF) @(negedge clk);
         sck = 1;
         rx[b] = so;
         repeat (HALF) @(negedge clk);
         sck = 0;
      end
   endtask

   task automatic send(input logic [7:0] tx);
      logic [7:0] d;
      xfer(tx, d);
   endtask

   task automatic cs_on;
      cs_n = 0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic cs_off;
      repeat (HALF) @(negedge clk);
      cs_n = 1;
      repeat (10) @(negedge clk);
   endtask

   task automatic rd_status(output logic [7:0] s);
      cs_on();
      send(8'h05);
      xfer(8'h00, s);
      cs_off();
   endtask

   task automatic wren;
      cs_on(); send(8'h06); cs_off();
   endtask

   task automatic wait_idle;
      logic [7:0] s;
      for (int k = 0; k < 40; k++) begin
         rd_status(s);
         if (!s[0]) return;
      end
      chk("R4 busy never ends", 1, 0);
   endtask

   function automatic logic [7:0] pat(input logic [7:0] fill, input int i);
      return fill + 8'(i) + ((i >= 256) ? 8'h40 : 8'h00);
   endfunction

   function automatic bit locked(input logic [23:0] a);
      return LOCK[a[10:9]];
   endfunction

   // page compare against the bench model; one check per page
   task automatic cmp_page(input string req, input logic [AW-1:0] base);
      int bad = 0;
      logic [7:0] a_v = 0, e_v = 0;
      for (int j = 0; j < 256; j++) begin
         @(negedge clk);
         rd_addr = {base[AW-1:8], 8'(j)};
         #1;
         if (rd_data !== model[{base[AW-1:8], 8'(j)}] && bad == 0) begin
            bad = 1; a_v = rd_data; e_v = model[{base[AW-1:8], 8'(j)}];
         end
      end
      chk(req, a_v, e_v);
   endtask

   // shift a program command; update model when it should commit, return expected error flag
   task automatic prog(input logic [23:0] a, input int len, input logic [7:0] fill,
                       output bit exp_err);
      logic [7:0] pb [256];
      bit pm [256];
      logic [AW-1:0] pg;
      exp_err = 0;
      for (int j = 0; j < 256; j++) pm[j] = 0;
      cs_on();
      send(8'h02); send(a[23:16]); send(a[15:8]); send(a[7:0]);
      for (int i = 0; i < len; i++) begin
         send(pat(fill, i));
         pb[8'(a[7:0] + 8'(i))] = pat(fill, i);
         pm[8'(a[7:0] + 8'(i))] = 1;
      end
      cs_off();
      pg = a[AW-1:0];
      if (!locked(a)) begin
         for (int j = 0; j < 256; j++) if (pm[j]) begin
            if ((model[{pg[AW-1:8], 8'(j)}] & pb[j]) != pb[j]) exp_err = 1;
            model[{pg[AW-1:8], 8'(j)}] &= pb[j];
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] s;
      bit ee;
      for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk("R1 so", so, 0);
      rd_status(s);
      chk("R1 status", s, 8'h00);
      cmp_page("R1 erased array", 11'h000);

      // R3 program without write enable
      prog(24'h000020, 2, 8'h00, ee);
      for (int i = 0; i < 2; i++) model[11'h020 + i] = 8'hFF;
      cmp_page("R3 no-WEL program ignored", 11'h000);
      rd_status(s);
      chk("R3 wel stays 0", s, 8'h00);

      // R2 write enable
      wren();
      rd_status(s);
      chk("R2 wel set", s, 8'h02);

      // R8 incomplete address
      cs_on(); send(8'h02); send(8'h00); send(8'h00); cs_off();
      rd_status(s);
      chk("R8 short address clears wel", s, 8'h00);
      // R8 address but no data
      wren();
      cs_on(); send(8'h02); send(8'h00); send(8'h00); send(8'h30); cs_off();
      rd_status(s);
      chk("R8 no data clears wel", s, 8'h00);
      cmp_page("R8 nothing programmed", 11'h000);

      // R9 odd clock count
      wren();
      cs_on(); send(8'h02); send(8'h00); send(8'h00); send(8'h40); send(8'h00);
      for (int b = 0; b < 3; b++) begin
         repeat (HALF) @(negedge clk); sck = 1;
         repeat (HALF) @(negedge clk); sck = 0;
      end
      cs_off();
      rd_status(s);
      chk("R9 odd count clears wel", s, 8'h00);
      cmp_page("R9 nothing programmed", 11'h000);

      // table: R4 commit, R5 wrap, R6 overrun, R10 lock, R7 alias/untouched
      for (int v = 0; v < 6; v++) begin
         wren();
         prog(VECS[v].addr, int'(VECS[v].len), VECS[v].fill, ee);
         rd_status(s);
         chk(locked(VECS[v].addr) ? "R10 locked busy" : "R4 busy in cycle",
             s[1:0], locked(VECS[v].addr) ? 0 : 1);
         wait_idle();
         rd_status(s);
         chk("R4 status after cycle", s, ee ? 8'h20 : 8'h00);
         cmp_page(v == 1 ? "R5 page wrap" : v == 2 ? "R6 last 256 kept" :
                  v == 3 ? "R10 locked page" : "R7 page contents",
                  VECS[v].addr[AW-1:0]);
      end

      // R11 0-to-1 needed sets error; next commit clears it
      wren();
      prog(24'h000010, 1, 8'hFF, ee);
      wait_idle();
      rd_status(s);
      chk("R11 error flag", s, 8'h20);
      cmp_page("R11 AND result", 11'h000);
      wren();
      prog(24'h000011, 1, 8'h00, ee);
      wait_idle();
      rd_status(s);
      chk("R11 error cleared", s, 8'h00);

      // R12 write enable during busy ignored
      wren();
      prog(24'h000300, 1, 8'h77, ee);
      wren();
      rd_status(s);
      chk("R12 busy, wel not set", s, 8'h01);
      wait_idle();
      rd_status(s);
      chk("R12 wel after cycle", s, 8'h00);
      cmp_page("R12 committed data", 11'h300);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule